// File: doc/BRIEF.md
# Gradient-descent channel estimate updater

This block performs one refinement pass on a complex channel-estimate matrix without inverting any matrix. For every entry it forms the product of one row of the current estimate with one column of the real auto-correlation matrix. It subtracts the matching cross-correlation entry from that product. It scales the difference down by a power-of-two step, subtracts the result from the old estimate entry, and clamps the outcome to the signed 8-bit range. The real and imaginary planes of the estimate are processed one after the other. A single multiply-accumulate unit serves the whole pass.

The three matrices live in memories outside the block. The block drives their read addresses and expects the data one clock later. The estimate memory has two banks. A pass reads only the bank named by `a_rd_bank` and writes every result into the other bank. When the pass ends, `done` pulses and the bank pointer flips, so the next pass reads the fresh estimate. Software or a sequencer issues a `start` pulse for each pass. It loads the correlation memories between passes.

Top module: `gd_chan_update`

## Requirements
- R1: A `start` pulse sampled high while the block is idle begins a pass. The estimate memory is addressed as {plane, row, column}, with plane 0 the real part and plane 1 the imaginary part. The auto-correlation memory is addressed as {k, column}, giving entry (k, column). The cross-correlation memory uses the same {plane, row, column} layout. Every memory returns its data on the clock after the address is presented.
- R2: Each written entry equals sat8(A[p][i][j] − ((Σk A[p][i][k]·Rbb[k][j] − Rbr[p][i][j]) >>> MU_SHIFT)). All values are two's complement: A and Rbb are 8-bit, Rbr is 16-bit, and MU_SHIFT defaults to 8.
- R3: The step is an arithmetic right shift that rounds toward minus infinity. For example, a difference of −1 gives −1, and a difference of 255 gives 0.
- R4: A result above 127 is written as 127, and a result below −128 is written as −128.
- R5: During a pass, every read of the estimate uses bank `a_rd_bank`. Every write goes to the other bank, and each of the 2·NROW·NDIM entries is written exactly once.
- R6: `done` is high for exactly one cycle, in the cycle after the last write. It is first seen after the (S+2)-th rising edge, where S = 2·NROW·NDIM·(NDIM+1) and the edge that samples `start` counts as the first.
- R7: `a_rd_bank` toggles when `done` rises and at no other time, so the next pass reads the results just written.
- R8: A `start` that arrives while a pass is in flight is ignored. This includes a `start` in the cycle of the final write. A `start` in the `done` cycle begins a new pass.
- R9: After reset, `done` and `a_wr_en` are low and `a_rd_bank` is 0.
- R10: The accumulator holds the full sum of NDIM products without wrapping. For example, four products of −64·−128 sum to 32768 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one update pass |
| done | output | 1 | One-cycle pulse after the last result is written |
| a_rd_bank | output | 1 | Estimate bank holding the current matrix |
| a_rd_addr | output | 1+log2(NROW)+log2(NDIM) | Estimate read address {plane,row,col} |
| a_rd_data | input | DATA_W | Estimate read data, one cycle after the address |
| rbb_rd_addr | output | 2·log2(NDIM) | Auto-correlation read address {k,col} |
| rbb_rd_data | input | RBB_W | Auto-correlation read data |
| rbr_rd_addr | output | 1+log2(NROW)+log2(NDIM) | Cross-correlation read address {plane,row,col} |
| rbr_rd_data | input | RBR_W | Cross-correlation read data |
| a_wr_en | output | 1 | Write strobe for a new estimate entry |
| a_wr_bank | output | 1 | Bank receiving new entries |
| a_wr_addr | output | 1+log2(NROW)+log2(NDIM) | Write address {plane,row,col} |
| a_wr_data | output | DATA_W | New estimate entry |

## Verification
Two functions can meet in one cycle: the final write of a pass and the arrival of a new `start`. The bench raises `start` in the cycle of the final write. It then expects no further write and no further `done` over two pass lengths, and it expects the bank pointer to stay put. The bench also raises `start` in the `done` cycle itself. In that case the second pass must begin at once and must compute from the bank written by the first pass. Its results are compared against arithmetic done in the bench on that bank.

// File: rtl/gd_pkg.sv
// Shared types and width helpers for the gradient-descent estimate updater.
// Assumes operand widths stay well below 31 bits.
package gd_pkg;

    // Kind of read slot issued by the scheduler.
    typedef enum logic [1:0] {
        SK_FIRST = 2'd0,   // first product of a dot product, clears the sum
        SK_MAC   = 2'd1,   // further product, adds into the sum
        SK_FIN   = 2'd2    // fetch old entry and cross-correlation, then write
    } slot_e;

    // Accumulator width that holds n signed products without wrapping.
    function automatic int gd_acc_width(int dw, int rw, int n);
        return dw + rw + $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/gd_sched.sv
// Read-slot scheduler: walks plane, row, column and the inner index k.
// Each output entry takes NDIM product slots followed by one finishing slot.
// Assumes NROW and NDIM are powers of two, each at least 2.
module gd_sched
    import gd_pkg::*;
#(
    parameter int NROW  = 2,
    parameter int NDIM  = 4,
    parameter int ROW_W = 1,
    parameter int COL_W = 2,
    parameter int KW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_go,
    output logic             run,
    output slot_e            iss_kind,
    output logic             iss_last,
    output logic             iss_ch,
    output logic [ROW_W-1:0] iss_row,
    output logic [COL_W-1:0] iss_col,
    output logic [COL_W-1:0] iss_k
);

    logic [KW-1:0] k;
    logic          last_k, last_col, last_row;

    // Decode the position of the current slot.
    always_comb begin
        last_k   = (k == KW'(NDIM));
        last_col = (iss_col == COL_W'(NDIM - 1));
        last_row = (iss_row == ROW_W'(NROW - 1));
        if (k == '0)      iss_kind = SK_FIRST;
        else if (last_k)  iss_kind = SK_FIN;
        else              iss_kind = SK_MAC;
        iss_last = last_k && last_col && last_row && iss_ch;
        iss_k    = k[COL_W-1:0];
    end

    // Advance the slot counters and stop after the final slot of the pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            k       <= '0;
            iss_col <= '0;
            iss_row <= '0;
            iss_ch  <= 1'b0;
        end else if (start_go) begin
            run     <= 1'b1;
            k       <= '0;
            iss_col <= '0;
            iss_row <= '0;
            iss_ch  <= 1'b0;
        end else if (run) begin
            if (last_k) begin
                k <= '0;
                if (last_col) begin
                    iss_col <= '0;
                    if (last_row) begin
                        iss_row <= '0;
                        iss_ch  <= ~iss_ch;
                        if (iss_ch) run <= 1'b0;
                    end else begin
                        iss_row <= iss_row + 1'b1;
                    end
                end else begin
                    iss_col <= iss_col + 1'b1;
                end
            end else begin
                k <= k + 1'b1;
            end
        end
    end

    // R1: a pass always begins at the origin of the walk.
    a_r1_begin_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (k == '0 && iss_col == '0 && iss_row == '0 && !iss_ch));

    // R5: counters never leave the matrix while running.
    a_r5_walk_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (k <= KW'(NDIM) && 32'(iss_row) < NROW && 32'(iss_col) < NDIM));

endmodule

// File: rtl/gd_mac.sv
// Single multiply-accumulate unit. On a clearing slot it loads the product;
// otherwise it adds the product to the running sum. Holds when not enabled.
module gd_mac #(
    parameter int DATA_W = 8,
    parameter int RBB_W  = 8,
    parameter int ACC_W  = 19
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     clr,
    input  logic signed [DATA_W-1:0] a_val,
    input  logic signed [RBB_W-1:0]  rbb_val,
    output logic signed [ACC_W-1:0]  acc
);

    logic signed [ACC_W-1:0] a_x, b_x, prod;

    // Widen both operands before multiplying.
    always_comb begin
        a_x  = ACC_W'(a_val);
        b_x  = ACC_W'(rbb_val);
        prod = a_x * b_x;
    end

    // Load or accumulate one product per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (en)  acc <= clr ? prod : acc + prod;
    end

endmodule

// File: rtl/gd_finish.sv
// Finishing stage: subtracts the cross-correlation from the dot product,
// scales by an arithmetic right shift, updates the old entry and clamps it.
// Purely combinational.
module gd_finish #(
    parameter int DATA_W   = 8,
    parameter int RBR_W    = 16,
    parameter int ACC_W    = 19,
    parameter int MU_SHIFT = 8
) (
    input  logic signed [ACC_W-1:0]  acc,
    input  logic signed [RBR_W-1:0]  rbr_val,
    input  logic signed [DATA_W-1:0] a_old,
    output logic signed [DATA_W-1:0] a_new
);

    localparam int WIDE = ((ACC_W > RBR_W) ? ACC_W : RBR_W) + 2;
    localparam logic signed [WIDE-1:0] HI = WIDE'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [WIDE-1:0] LO = -HI - WIDE'(1);

    logic signed [WIDE-1:0] diff, stepv, nxt;

    // Gradient step followed by clamping to the entry width.
    always_comb begin
        diff  = WIDE'(acc) - WIDE'(rbr_val);
        stepv = diff >>> MU_SHIFT;
        nxt   = WIDE'(a_old) - stepv;
        if (nxt > HI)       a_new = HI[DATA_W-1:0];
        else if (nxt < LO)  a_new = LO[DATA_W-1:0];
        else                a_new = nxt[DATA_W-1:0];
    end

endmodule

// File: rtl/gd_chan_update.sv
// Top of the gradient-descent channel estimate updater.
// Drives synchronous-read memories (one cycle latency) for the estimate,
// auto-correlation and cross-correlation matrices; writes new entries to the
// estimate bank not being read and flips the bank pointer when a pass ends.
// Assumes NROW and NDIM are powers of two, each at least 2.
module gd_chan_update
    import gd_pkg::*;
#(
    parameter int NROW     = 2,
    parameter int NDIM     = 4,
    parameter int DATA_W   = 8,
    parameter int RBB_W    = 8,
    parameter int RBR_W    = 16,
    parameter int MU_SHIFT = 8,
    localparam int ROW_W   = $clog2(NROW),
    localparam int COL_W   = $clog2(NDIM),
    localparam int A_AW    = 1 + ROW_W + COL_W,
    localparam int B_AW    = 2 * COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              a_rd_bank,
    output logic [A_AW-1:0]   a_rd_addr,
    input  logic [DATA_W-1:0] a_rd_data,
    output logic [B_AW-1:0]   rbb_rd_addr,
    input  logic [RBB_W-1:0]  rbb_rd_data,
    output logic [A_AW-1:0]   rbr_rd_addr,
    input  logic [RBR_W-1:0]  rbr_rd_data,
    output logic              a_wr_en,
    output logic              a_wr_bank,
    output logic [A_AW-1:0]   a_wr_addr,
    output logic [DATA_W-1:0] a_wr_data
);

    localparam int KW    = $clog2(NDIM + 1);
    localparam int ACC_W = gd_acc_width(DATA_W, RBB_W, NDIM);

    logic             run, start_go;
    slot_e            iss_kind, kind2;
    logic             iss_last, iss_ch, v2, last2, bank;
    logic [ROW_W-1:0] iss_row;
    logic [COL_W-1:0] iss_col, iss_k;
    logic [A_AW-1:0]  waddr2;
    logic signed [ACC_W-1:0]  acc;
    logic signed [DATA_W-1:0] a_new;

    // A pass may begin only when neither stage holds work.
    assign start_go = start && !run && !v2;

    gd_sched #(
        .NROW(NROW), .NDIM(NDIM), .ROW_W(ROW_W), .COL_W(COL_W), .KW(KW)
    ) u_sched (
        .clk(clk), .rst_n(rst_n), .start_go(start_go), .run(run),
        .iss_kind(iss_kind), .iss_last(iss_last), .iss_ch(iss_ch),
        .iss_row(iss_row), .iss_col(iss_col), .iss_k(iss_k)
    );

    // Form read addresses for the slot being issued.
    always_comb begin
        a_rd_addr   = {iss_ch, iss_row, (iss_kind == SK_FIN) ? iss_col : iss_k};
        rbb_rd_addr = {iss_k, iss_col};
        rbr_rd_addr = {iss_ch, iss_row, iss_col};
        a_rd_bank   = bank;
    end

    // Carry slot information alongside the returning read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2     <= 1'b0;
            kind2  <= SK_FIRST;
            last2  <= 1'b0;
            waddr2 <= '0;
        end else begin
            v2     <= run;
            kind2  <= iss_kind;
            last2  <= run && iss_last;
            waddr2 <= {iss_ch, iss_row, iss_col};
        end
    end

    gd_mac #(
        .DATA_W(DATA_W), .RBB_W(RBB_W), .ACC_W(ACC_W)
    ) u_mac (
        .clk(clk), .rst_n(rst_n),
        .en(v2 && kind2 != SK_FIN), .clr(kind2 == SK_FIRST),
        .a_val($signed(a_rd_data)), .rbb_val($signed(rbb_rd_data)), .acc(acc)
    );

    gd_finish #(
        .DATA_W(DATA_W), .RBR_W(RBR_W), .ACC_W(ACC_W), .MU_SHIFT(MU_SHIFT)
    ) u_finish (
        .acc(acc), .rbr_val($signed(rbr_rd_data)),
        .a_old($signed(a_rd_data)), .a_new(a_new)
    );

    // Write port toward the bank not being read.
    always_comb begin
        a_wr_en   = v2 && (kind2 == SK_FIN);
        a_wr_bank = ~bank;
        a_wr_addr = waddr2;
        a_wr_data = $unsigned(a_new);
    end

    // Signal completion and swap banks after the final write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            bank <= 1'b0;
        end else begin
            done <= a_wr_en && last2;
            if (a_wr_en && last2) bank <= ~bank;
        end
    end

    // R6: completion is a single-cycle pulse.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: completion directly follows a write.
    a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(a_wr_en));

    // R7: the read bank changes only together with completion.
    a_r7_bank_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(a_rd_bank));

    // R8: the scheduler only restarts once the write stage has drained.
    a_r8_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(!v2));

endmodule

// File: tb/gd_chan_update_tb.sv
// Self-checking bench: small configuration, memory models with one-cycle
// read latency, expected results computed arithmetically per entry.
module gd_chan_update_tb;

    localparam int NROW = 2;
    localparam int NDIM = 4;
    localparam int NENT = 2 * NROW * NDIM;
    localparam int S    = NENT * (NDIM + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        done, a_rd_bank, a_wr_en, a_wr_bank;
    logic [3:0]  a_rd_addr, rbb_rd_addr, rbr_rd_addr, a_wr_addr;
    logic [7:0]  a_q, rbb_q, a_wr_data;
    logic [15:0] rbr_q;

    logic signed [7:0]  amem [0:1][0:NENT-1];
    logic signed [7:0]  rbbm [0:NDIM*NDIM-1];
    logic signed [15:0] rbrm [0:NENT-1];
    logic        ld_en = 1'b0, ld_bank = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;

    int n_checks = 0, n_fail = 0;
    int ex [0:NENT-1];
    logic bank_exp = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gd_chan_update u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .a_rd_bank(a_rd_bank), .a_rd_addr(a_rd_addr), .a_rd_data(a_q),
        .rbb_rd_addr(rbb_rd_addr), .rbb_rd_data(rbb_q),
        .rbr_rd_addr(rbr_rd_addr), .rbr_rd_data(rbr_q),
        .a_wr_en(a_wr_en), .a_wr_bank(a_wr_bank),
        .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data)
    );

    // Memory models: synchronous reads, design writes, bench loader.
    always_ff @(posedge clk) begin
        a_q   <= amem[a_rd_bank][a_rd_addr];
        rbb_q <= rbbm[rbb_rd_addr];
        rbr_q <= rbrm[rbr_rd_addr];
        if (a_wr_en) amem[a_wr_bank][a_wr_addr] <= a_wr_data;
        else if (ld_en) amem[ld_bank][ld_addr] <= ld_data;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Fill the estimate bank; mode 0 random, mode 1 constant.
    task automatic fill_a(input logic bnk, input int mode, input int val);
        for (int e = 0; e < NENT; e++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_bank = bnk; ld_addr = 4'(e);
            ld_data = (mode == 0) ? 8'($urandom) : 8'(val);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic fill_corr(input int mode, input int bv, input int rv);
        for (int e = 0; e < NDIM * NDIM; e++)
            rbbm[e] = (mode == 0) ? 8'($urandom) : 8'(bv);
        for (int e = 0; e < NENT; e++)
            rbrm[e] = (mode == 0) ? 16'($urandom) : 16'(rv);
    endtask

    // Expected entries from the update rule on the bench's own arrays.
    task automatic compute_exp(input logic bnk);
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < NROW; i++)
                for (int j = 0; j < NDIM; j++) begin
                    int acc, d, nv, base;
                    base = c * NROW * NDIM + i * NDIM;
                    acc = 0;
                    for (int k = 0; k < NDIM; k++)
                        acc += int'(amem[bnk][base + k]) * int'(rbbm[k * NDIM + j]);
                    d  = acc - int'(rbrm[base + j]);
                    nv = int'(amem[bnk][base + j]) - (d >>> 8);
                    if (nv > 127) nv = 127;
                    if (nv < -128) nv = -128;
                    ex[base + j] = nv;
                end
    endtask

    // Count negedges until done; raise start at count 'extra'.
    task automatic wait_done(input int extra, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            start = (n == extra);
            if (done) break;
            if (n > 10 * S) begin
                check(1'b0, "R6 watchdog waiting for done", n, S + 2);
                summary();
            end
        end
    endtask

    // One pass: expected values, latency, pulse width, bank flip, results.
    task automatic full_iter(input string tag, input int extra, input bit pre_started);
        int n, lat;
        logic old_b;
        old_b = bank_exp;
        compute_exp(old_b);
        lat = pre_started ? S + 1 : S + 2;
        if (!pre_started) begin
            @(negedge clk);
            start = 1'b1;
        end
        wait_done(extra, n);
        check(n == lat, "R6 done latency", n, lat);
        check(a_rd_bank == ~old_b, "R7 bank flips with done", int'(a_rd_bank), int'(~old_b));
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R6 done lasts one cycle", int'(done), 0);
        bank_exp = ~old_b;
        for (int e = 0; e < NENT; e++)
            check(int'(amem[~old_b][e]) == ex[e], tag, int'(amem[~old_b][e]), ex[e]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R6 global watchdog", 0, 1);
        summary();
    end

    initial begin
        fill_corr(0, 0, 0);
        for (int e = 0; e < NENT; e++) begin
            amem[0][e] = '0;
            amem[1][e] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state.
        check(done == 1'b0, "R9 done low after reset", int'(done), 0);
        check(a_wr_en == 1'b0, "R9 no write after reset", int'(a_wr_en), 0);
        check(a_rd_bank == 1'b0, "R9 bank 0 after reset", int'(a_rd_bank), 0);

        // R1 R2 R5: random data, then chained passes reading prior results.
        fill_a(bank_exp, 0, 0);
        for (int t = 0; t < 4; t++) begin
            fill_corr(0, 0, 0);
            full_iter("R2 random pass result", 0, 1'b0);
        end
        for (int t = 0; t < 3; t++) begin
            fill_a(bank_exp, 0, 0);
            fill_corr(0, 0, 0);
            full_iter("R5 fresh random pass result", 0, 1'b0);
        end

        // R4: push above the top and below the bottom of the range.
        fill_a(bank_exp, 1, 127);
        fill_corr(1, -128, 0);
        full_iter("R4 clamp to 127", 0, 1'b0);
        fill_a(bank_exp, 1, -128);
        fill_corr(1, -128, -32768);
        full_iter("R4 clamp to -128", 0, 1'b0);

        // R10: sum of 32768 needs more than 16 bits; result stays -64.
        fill_a(bank_exp, 1, -64);
        fill_corr(1, -128, 32767);
        full_iter("R10 wide accumulator result", 0, 1'b0);

        // R3: rounding of the shift toward minus infinity.
        fill_a(bank_exp, 1, 0);
        fill_corr(1, 0, 0);
        rbrm[0] = 16'sd1;    rbrm[1] = 16'sd255;  rbrm[2] = 16'sd256;
        rbrm[3] = 16'sd257;  rbrm[4] = -16'sd1;   rbrm[5] = -16'sd255;
        rbrm[6] = -16'sd256; rbrm[7] = -16'sd257;
        full_iter("R3 shift rounding", 0, 1'b0);

        // R8: start in the middle of a pass has no effect.
        fill_a(bank_exp, 0, 0);
        fill_corr(0, 0, 0);
        full_iter("R8 start mid pass ignored", 10, 1'b0);

        // R8: start in the final write cycle is ignored.
        fill_corr(0, 0, 0);
        full_iter("R8 pass before late start", S + 1, 1'b0);
        begin
            int stray;
            logic b0;
            stray = 0;
            b0 = a_rd_bank;
            repeat (2 * S) begin
                @(negedge clk);
                if (a_wr_en || done) stray++;
            end
            check(stray == 0, "R8 start in final write cycle ignored", stray, 0);
            check(a_rd_bank == b0, "R8 bank unchanged after ignored start", int'(a_rd_bank), int'(b0));
        end

        // R8 R7: start in the done cycle begins a pass on the new bank.
        fill_corr(0, 0, 0);
        full_iter("R8 pass before back-to-back start", S + 2, 1'b0);
        full_iter("R7 back-to-back pass reads new bank", 0, 1'b1);

        summary();
    end

endmodule